// File: doc/BRIEF.md
# Extended Subtract and Negate Unit

This block is the execution stage for the complemented-operand subtract group of a 32-bit integer pipeline. It handles four operations: negate, subtract-from with carry, subtract-from-zero with carry, and subtract-from-minus-one with carry. It takes the decoded instruction fields, two 32-bit register operands, and the current carry and summary-overflow flags. It returns one registered result per accepted instruction.

The arithmetic is always done on 32 bits. The destination value is 64 bits wide, and its upper half is always zero. Each of the three carry-using forms has its own carry-out rule. The overflow flag is written only when the instruction's overflow-enable bit is set. A set overflow also sets the summary-overflow flag, which never clears here. The condition field is written only when the record bit is set, and it classifies the 32-bit result as a signed number.

Any instruction that does not decode to one of the four operations is flagged as illegal and writes no state. Every result appears exactly one clock after the cycle in which the instruction is presented.

Top module: `xsub_unit`

## Requirements
- R1: An instruction is legal only when the primary opcode field is 31 and the extended opcode field is one of: 104 (negate), 136 (subtract-from with carry), 200 (subtract-from-zero with carry) or 232 (subtract-from-minus-one with carry). For a legal instruction, `gpr_we` is 1 and `gpr_idx` equals the destination field.
- R2: Subtract-from with carry writes ~A + B + CA mod 2^32. The carry out is 1 when B > A (unsigned), or when B == A and CA in is 1. Otherwise it is 0. `ca_we` is 1.
- R3: Subtract-from-zero with carry writes ~A + CA mod 2^32. The carry out is 1 only when A == 0 and CA in is 1. `ca_we` is 1.
- R4: Subtract-from-minus-one with carry writes ~A + CA - 1 mod 2^32. The carry out is 1 when A != 0xFFFFFFFF or CA in is 1. `ca_we` is 1.
- R5: Negate writes the 32-bit two's complement of A. It leaves the carry alone (`ca_we` = 0, `ca_out` = 0). With OE set, the overflow output is 1 only for A = 0x80000000, whose result is 0x80000000.
- R6: The upper 32 bits of `gpr_data` are always zero. For example, negating 5 gives 0x00000000FFFFFFFB.
- R7: For the three subtract forms, OE = 1 sets `ov_we` = 1. In that case `ov_out` is 1 exactly when the exact signed value (B - A - 1 + CA, -A - 1 + CA, or -A - 2 + CA, with A and B read as signed) lies outside [-2^31, 2^31 - 1]. OE = 0 gives `ov_we` = 0 and `ov_out` = 0.
- R8: When `ov_we` = 1, `so_out` = `so_in` OR `ov_out`, so a set summary overflow stays set. When `ov_we` = 0, `so_out` = 0.
- R9: Rc = 1 sets `cr_we` = 1. Then `cr0` = {LT, GT, EQ, SO}, from bit 3 down to bit 0. LT is bit 31 of the result. EQ means the result is zero. GT means neither LT nor EQ. SO is `so_in` OR `ov_out`. Rc = 0 gives `cr_we` = 0 and `cr0` = 0.
- R10: An illegal instruction sets `illegal` = 1. All write enables are 0, and all data and flag outputs are 0.
- R11: The outputs are registered and are due one clock after `in_valid`. A cycle without `in_valid` gives all outputs 0 in the next cycle. Reset clears all outputs. Within an accepted result, every data or flag output whose write enable is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| ins_prim | input | 6 | Primary opcode field |
| ins_rd | input | 5 | Destination register field |
| ins_oe | input | 1 | Overflow-enable bit |
| ins_xo | input | 9 | Extended opcode field |
| ins_rc | input | 1 | Record bit (update condition field) |
| opa | input | 32 | Operand A (register RA value) |
| opb | input | 32 | Operand B (register RB value) |
| ca_in | input | 1 | Current carry flag |
| so_in | input | 1 | Current summary-overflow flag |
| out_valid | output | 1 | Result present |
| illegal | output | 1 | Instruction not recognised |
| gpr_we | output | 1 | Destination write enable |
| gpr_idx | output | 5 | Destination register index |
| gpr_data | output | 64 | Destination value, upper half zero |
| ca_we | output | 1 | Carry write enable |
| ca_out | output | 1 | New carry |
| ov_we | output | 1 | Overflow and summary-overflow write enable |
| ov_out | output | 1 | New overflow |
| so_out | output | 1 | New summary overflow |
| cr_we | output | 1 | Condition field write enable |
| cr0 | output | 4 | Condition field {LT,GT,EQ,SO} |

## Verification
Every output of this unit passes through one register stage. The destination value, carry, overflow, summary overflow, condition field and illegal flag for an instruction presented in one cycle are therefore all due in the next cycle, and an idle cycle is due to read all-zero one cycle later. The bench changes inputs just after a falling edge and computes the expected result from a behavioural model using 64-bit signed integers. At the following falling edge, one full clock and one register later, it compares every output of that cycle's instruction. Back-to-back instructions are compared this way on every clock, so a result landing a cycle early or late shows up as a mismatch.

// File: rtl/xsub_pkg.sv
package xsub_pkg;

    localparam int PRIM_W    = 6;
    localparam int XO_W      = 9;
    localparam int REG_IDX_W = 5;
    localparam int CR_W      = 4;

    localparam logic [PRIM_W-1:0] PRIM_XFORM = 6'd31;
    localparam logic [XO_W-1:0]   XO_NEG     = 9'd104;
    localparam logic [XO_W-1:0]   XO_SUBFE   = 9'd136;
    localparam logic [XO_W-1:0]   XO_SUBFZE  = 9'd200;
    localparam logic [XO_W-1:0]   XO_SUBFME  = 9'd232;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_NEG,
        OP_SUBFE,
        OP_SUBFZE,
        OP_SUBFME
    } xop_e;

    typedef struct packed {
        xop_e                 op;
        logic                 illegal;
        logic [REG_IDX_W-1:0] rd;
        logic                 oe;
        logic                 rc;
    } xdec_t;

endpackage

// File: rtl/xsub_decode.sv
module xsub_decode
    import xsub_pkg::*;
(
    input  logic [PRIM_W-1:0]    prim,
    input  logic [REG_IDX_W-1:0] rd,
    input  logic                 oe,
    input  logic [XO_W-1:0]      xo,
    input  logic                 rc,
    output xdec_t                dec
);

    xop_e op_sel;

    always_comb begin
        op_sel = OP_NONE;
        if (prim == PRIM_XFORM) begin
            unique case (xo)
                XO_NEG:    op_sel = OP_NEG;
                XO_SUBFE:  op_sel = OP_SUBFE;
                XO_SUBFZE: op_sel = OP_SUBFZE;
                XO_SUBFME: op_sel = OP_SUBFME;
                default:   op_sel = OP_NONE;
            endcase
        end
    end

    always_comb begin
        dec         = '0;
        dec.op      = op_sel;
        dec.illegal = (op_sel == OP_NONE);
        dec.rd      = rd;
        dec.oe      = oe;
        dec.rc      = rc;
    end

endmodule

// File: rtl/xsub_arith.sv
module xsub_arith
    import xsub_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  xop_e              op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              ca_in,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              ovf
);

    localparam int WIDE_W = DATA_W + 1;

    logic [DATA_W-1:0] inv_a;
    logic [DATA_W-1:0] addend;
    logic              cin;
    logic [WIDE_W-1:0] wide;

    // Every form is ~A + addend + carry-in, with the addend and carry-in
    // picked per operation.
    always_comb begin
        inv_a = ~opa;
        unique case (op)
            OP_NEG: begin
                addend = '0;
                cin    = 1'b1;
            end
            OP_SUBFE: begin
                addend = opb;
                cin    = ca_in;
            end
            OP_SUBFZE: begin
                addend = '0;
                cin    = ca_in;
            end
            OP_SUBFME: begin
                addend = '1;
                cin    = ca_in;
            end
            default: begin
                addend = '0;
                cin    = 1'b0;
            end
        endcase
    end

    always_comb begin
        wide  = {1'b0, inv_a} + {1'b0, addend} + {{DATA_W{1'b0}}, cin};
        sum   = wide[DATA_W-1:0];
        carry = wide[DATA_W];
        // Signed overflow: both addends share a sign and the sum differs.
        ovf   = (inv_a[DATA_W-1] == addend[DATA_W-1]) &&
                (sum[DATA_W-1] != inv_a[DATA_W-1]);
    end

endmodule

// File: rtl/xsub_flags.sv
module xsub_flags
    import xsub_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  xdec_t             dec,
    input  logic [DATA_W-1:0] sum,
    input  logic              carry,
    input  logic              ovf,
    input  logic              so_in,
    output logic              ca_we,
    output logic              ca_o,
    output logic              ov_we,
    output logic              ov_o,
    output logic              so_o,
    output logic              cr_we,
    output logic [CR_W-1:0]   cr0
);

    logic legal;
    logic res_lt;
    logic res_eq;
    logic res_gt;
    logic so_now;

    always_comb begin
        legal = !dec.illegal;

        ca_we = legal && (dec.op != OP_NEG);
        ca_o  = ca_we && carry;

        ov_we = legal && dec.oe;
        ov_o  = ov_we && ovf;
        so_o  = ov_we && (so_in || ovf);

        so_now = so_in || ov_o;
        res_lt = sum[DATA_W-1];
        res_eq = (sum == '0);
        res_gt = !res_lt && !res_eq;

        cr_we = legal && dec.rc;
        cr0   = cr_we ? {res_lt, res_gt, res_eq, so_now} : '0;
    end

endmodule

// File: rtl/xsub_unit.sv
module xsub_unit
    import xsub_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [PRIM_W-1:0]      ins_prim,
    input  logic [REG_IDX_W-1:0]   ins_rd,
    input  logic                   ins_oe,
    input  logic [XO_W-1:0]        ins_xo,
    input  logic                   ins_rc,
    input  logic [DATA_W-1:0]      opa,
    input  logic [DATA_W-1:0]      opb,
    input  logic                   ca_in,
    input  logic                   so_in,
    output logic                   out_valid,
    output logic                   illegal,
    output logic                   gpr_we,
    output logic [REG_IDX_W-1:0]   gpr_idx,
    output logic [2*DATA_W-1:0]    gpr_data,
    output logic                   ca_we,
    output logic                   ca_out,
    output logic                   ov_we,
    output logic                   ov_out,
    output logic                   so_out,
    output logic                   cr_we,
    output logic [CR_W-1:0]        cr0
);

    localparam int DEST_W = 2 * DATA_W;
    localparam int PAD_W  = DEST_W - DATA_W;
    localparam logic [DATA_W-1:0] INT_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic                 vld;
        logic                 ill;
        logic                 gpr_we;
        logic [REG_IDX_W-1:0] idx;
        logic [DEST_W-1:0]    data;
        logic                 ca_we;
        logic                 ca;
        logic                 ov_we;
        logic                 ov;
        logic                 so;
        logic                 cr_we;
        logic [CR_W-1:0]      cr;
    } stage_t;

    xdec_t             dec;
    logic [DATA_W-1:0] sum;
    logic              carry;
    logic              ovf;
    logic              f_ca_we;
    logic              f_ca;
    logic              f_ov_we;
    logic              f_ov;
    logic              f_so;
    logic              f_cr_we;
    logic [CR_W-1:0]   f_cr;
    stage_t            st_d;
    stage_t            st_q;

    xsub_decode u_decode (
        .prim (ins_prim),
        .rd   (ins_rd),
        .oe   (ins_oe),
        .xo   (ins_xo),
        .rc   (ins_rc),
        .dec  (dec)
    );

    xsub_arith #(.DATA_W(DATA_W)) u_arith (
        .op    (dec.op),
        .opa   (opa),
        .opb   (opb),
        .ca_in (ca_in),
        .sum   (sum),
        .carry (carry),
        .ovf   (ovf)
    );

    xsub_flags #(.DATA_W(DATA_W)) u_flags (
        .dec   (dec),
        .sum   (sum),
        .carry (carry),
        .ovf   (ovf),
        .so_in (so_in),
        .ca_we (f_ca_we),
        .ca_o  (f_ca),
        .ov_we (f_ov_we),
        .ov_o  (f_ov),
        .so_o  (f_so),
        .cr_we (f_cr_we),
        .cr0   (f_cr)
    );

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            st_d.vld   = 1'b1;
            st_d.ill   = dec.illegal;
            if (!dec.illegal) begin
                st_d.gpr_we = 1'b1;
                st_d.idx    = dec.rd;
                st_d.data   = {{PAD_W{1'b0}}, sum};
            end
            st_d.ca_we = f_ca_we;
            st_d.ca    = f_ca;
            st_d.ov_we = f_ov_we;
            st_d.ov    = f_ov;
            st_d.so    = f_so;
            st_d.cr_we = f_cr_we;
            st_d.cr    = f_cr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign illegal   = st_q.ill;
    assign gpr_we    = st_q.gpr_we;
    assign gpr_idx   = st_q.idx;
    assign gpr_data  = st_q.data;
    assign ca_we     = st_q.ca_we;
    assign ca_out    = st_q.ca;
    assign ov_we     = st_q.ov_we;
    assign ov_out    = st_q.ov;
    assign so_out    = st_q.so;
    assign cr_we     = st_q.cr_we;
    assign cr0       = st_q.cr;

    // R1: destination index follows the instruction field
    p_dest_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ins_prim == PRIM_XFORM && ins_xo == XO_SUBFE
        |=> gpr_we && gpr_idx == $past(ins_rd));

    // R3: nonzero A never produces a carry for subtract-from-zero
    p_subfze_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ins_prim == PRIM_XFORM && ins_xo == XO_SUBFZE && opa != '0
        |=> ca_we && !ca_out);

    // R4: A other than all-ones always carries for subtract-from-minus-one
    p_subfme_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ins_prim == PRIM_XFORM && ins_xo == XO_SUBFME && opa != '1
        |=> ca_we && ca_out);

    // R5: negate leaves carry untouched
    p_neg_keeps_ca_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ins_prim == PRIM_XFORM && ins_xo == XO_NEG
        |=> gpr_we && !ca_we && !ca_out);

    // R5: negate overflows only on the most negative value
    p_neg_ov_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ins_prim == PRIM_XFORM && ins_xo == XO_NEG && opa != INT_MIN
        |=> !ov_out);

    // R6: upper half of the destination is always clear
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> gpr_data[DEST_W-1:DATA_W] == '0);

    // R7: no overflow write without OE
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !ins_oe |=> !ov_we && !ov_out);

    // R8: a set summary overflow stays set when overflow is written
    p_so_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && so_in |=> !ov_we || so_out);

    // R9: the SO bit of the condition field is the updated summary overflow
    p_cr_so_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> !cr_we || (cr0[0] == ($past(so_in) || ov_out)));

    // R10: illegal instructions write nothing
    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> out_valid && !gpr_we && !ca_we && !ov_we && !cr_we);

    // R11: one-cycle latency, and idle cycles produce no result
    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !gpr_we && !illegal);

endmodule

// File: tb/xsub_unit_tb.sv
module xsub_unit_tb;

    typedef struct packed {
        logic        vld;
        logic        ill;
        logic        gpr_we;
        logic [4:0]  idx;
        logic [63:0] data;
        logic        ca_we;
        logic        ca;
        logic        ov_we;
        logic        ov;
        logic        so;
        logic        cr_we;
        logic [3:0]  cr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  ins_prim = '0;
    logic [4:0]  ins_rd = '0;
    logic        ins_oe = 1'b0;
    logic [8:0]  ins_xo = '0;
    logic        ins_rc = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        ca_in = 1'b0;
    logic        so_in = 1'b0;

    logic        out_valid;
    logic        illegal;
    logic        gpr_we;
    logic [4:0]  gpr_idx;
    logic [63:0] gpr_data;
    logic        ca_we;
    logic        ca_out;
    logic        ov_we;
    logic        ov_out;
    logic        so_out;
    logic        cr_we;
    logic [3:0]  cr0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xsub_unit u_dut (
        .clk, .rst_n, .in_valid, .ins_prim, .ins_rd, .ins_oe, .ins_xo, .ins_rc,
        .opa, .opb, .ca_in, .so_in, .out_valid, .illegal, .gpr_we, .gpr_idx,
        .gpr_data, .ca_we, .ca_out, .ov_we, .ov_out, .so_out, .cr_we, .cr0
    );

    function automatic exp_t model(input logic [5:0] p, input logic [4:0] rd,
                                   input logic oe, input logic [8:0] xo,
                                   input logic rc, input logic [31:0] a,
                                   input logic [31:0] b, input logic ca,
                                   input logic so);
        exp_t   e;
        longint sa;
        longint sb;
        longint ua;
        longint ub;
        longint t;
        logic   cy;
        logic   ovx;
        logic   sum_so;
        logic [31:0] r;
        e = '0;
        e.vld = 1'b1;
        if (p != 6'd31 || !(xo == 9'd104 || xo == 9'd136 || xo == 9'd200 || xo == 9'd232)) begin
            e.ill = 1'b1;
            return e;
        end
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ua = longint'({32'h0, a});
        ub = longint'({32'h0, b});
        cy = 1'b0;
        case (xo)
            9'd104: t = -sa;
            9'd136: begin
                t  = sb - sa - 1 + longint'(ca);
                cy = (ub > ua) || (ub == ua && ca);
            end
            9'd200: begin
                t  = -sa - 1 + longint'(ca);
                cy = (a == 32'h0) && ca;
            end
            default: begin
                t  = -sa - 2 + longint'(ca);
                cy = (a != 32'hFFFF_FFFF) || ca;
            end
        endcase
        ovx = (t > 64'sd2147483647) || (t < -64'sd2147483648);
        r = t[31:0];
        e.gpr_we = 1'b1;
        e.idx    = rd;
        e.data   = {32'h0, r};
        if (xo != 9'd104) begin
            e.ca_we = 1'b1;
            e.ca    = cy;
        end
        if (oe) begin
            e.ov_we = 1'b1;
            e.ov    = ovx;
            e.so    = so | ovx;
        end
        sum_so = so | (oe & ovx);
        if (rc) begin
            e.cr_we = 1'b1;
            e.cr = {r[31], !r[31] && r != 32'h0, r == 32'h0, sum_so};
        end
        return e;
    endfunction

    task automatic check(input exp_t e, input string tag);
        exp_t act;
        act = {out_valid, illegal, gpr_we, gpr_idx, gpr_data, ca_we, ca_out,
               ov_we, ov_out, so_out, cr_we, cr0};
        n_checks++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: actual data=%h ca=%b/%b ov=%b/%b so=%b cr=%b/%h ill=%b vld=%b idx=%0d | expected data=%h ca=%b/%b ov=%b/%b so=%b cr=%b/%h ill=%b vld=%b idx=%0d",
                     tag, act.data, act.ca_we, act.ca, act.ov_we, act.ov, act.so,
                     act.cr_we, act.cr, act.ill, act.vld, act.idx,
                     e.data, e.ca_we, e.ca, e.ov_we, e.ov, e.so,
                     e.cr_we, e.cr, e.ill, e.vld, e.idx);
        end
    endtask

    // Drive one cycle just after a falling edge; compare at the next one.
    task automatic issue(input logic v, input logic [5:0] p, input logic [4:0] rd,
                         input logic oe, input logic [8:0] xo, input logic rc,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic ca, input logic so, input string tag);
        exp_t e;
        in_valid = v;
        ins_prim = p;
        ins_rd   = rd;
        ins_oe   = oe;
        ins_xo   = xo;
        ins_rc   = rc;
        opa      = a;
        opb      = b;
        ca_in    = ca;
        so_in    = so;
        e = v ? model(p, rd, oe, xo, rc, a, b, ca, so) : '0;
        @(negedge clk);
        check(e, tag);
    endtask

    task automatic op(input logic [8:0] xo, input logic oe, input logic rc,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic ca, input logic so, input string tag);
        issue(1'b1, 6'd31, 5'd7, oe, xo, rc, a, b, ca, so, tag);
    endtask

    task automatic idle(input string tag);
        issue(1'b0, 6'd0, 5'd0, 1'b0, 9'd0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, tag);
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom_range(0, 5))
            0: return 32'h0;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h7FFF_FFFF;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check('0, "R11 reset state");
        rst_n = 1'b1;

        // R1: decode and destination field
        issue(1'b1, 6'd31, 5'd17, 1'b0, 9'd136, 1'b0, 32'd3, 32'd9, 1'b0, 1'b0, "R1 dest 17");
        // R5 / R6: negate
        op(9'd104, 1'b0, 1'b0, 32'd5, 32'h0, 1'b1, 1'b0, "R6 neg 5 upper zero");
        op(9'd104, 1'b1, 1'b0, 32'h8000_0000, 32'h0, 1'b0, 1'b0, "R5 neg int_min ov");
        op(9'd104, 1'b1, 1'b0, 32'h7FFF_FFFF, 32'h0, 1'b0, 1'b0, "R5 neg max no ov");
        op(9'd104, 1'b1, 1'b1, 32'h0, 32'h0, 1'b1, 1'b0, "R5 neg zero");
        // R2: subtract-from with carry
        op(9'd136, 1'b0, 1'b0, 32'd5, 32'd10, 1'b1, 1'b0, "R2 b>a");
        op(9'd136, 1'b0, 1'b0, 32'd10, 32'd10, 1'b0, 1'b0, "R2 b==a ca0");
        op(9'd136, 1'b0, 1'b0, 32'd10, 32'd10, 1'b1, 1'b0, "R2 b==a ca1");
        op(9'd136, 1'b0, 1'b0, 32'd11, 32'd10, 1'b1, 1'b0, "R2 b<a");
        // R3: subtract-from-zero with carry
        op(9'd200, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, "R3 a0 ca0");
        op(9'd200, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 1'b0, "R3 a0 ca1");
        op(9'd200, 1'b0, 1'b0, 32'd1, 32'h0, 1'b0, 1'b0, "R3 a1 ca0");
        op(9'd200, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, "R3 amax ca1");
        // R4: subtract-from-minus-one with carry
        op(9'd232, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, "R4 amax ca0");
        op(9'd232, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, "R4 amax ca1");
        op(9'd232, 1'b0, 1'b0, 32'd4, 32'h0, 1'b0, 1'b0, "R4 a4 ca0");
        // R7: signed overflow of the subtract forms
        op(9'd136, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, "R7 subfe ov");
        op(9'd200, 1'b1, 1'b0, 32'h8000_0000, 32'h0, 1'b1, 1'b0, "R7 subfze ov");
        op(9'd232, 1'b1, 1'b0, 32'h7FFF_FFFF, 32'h0, 1'b0, 1'b0, "R7 subfme ov");
        op(9'd232, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h0, 1'b0, 1'b0, "R7 oe clear");
        // R8: sticky summary overflow
        op(9'd136, 1'b1, 1'b0, 32'd1, 32'd2, 1'b0, 1'b1, "R8 so kept");
        op(9'd200, 1'b0, 1'b0, 32'd1, 32'h0, 1'b0, 1'b1, "R8 so not written");
        // R9: condition field
        op(9'd104, 1'b0, 1'b1, 32'd5, 32'h0, 1'b0, 1'b0, "R9 lt");
        op(9'd136, 1'b0, 1'b1, 32'd5, 32'd5, 1'b1, 1'b0, "R9 eq");
        op(9'd136, 1'b0, 1'b1, 32'd5, 32'd9, 1'b1, 1'b1, "R9 gt so");
        op(9'd232, 1'b1, 1'b1, 32'h7FFF_FFFF, 32'h0, 1'b0, 1'b0, "R9 so from ov");
        // R10: illegal instructions
        op(9'd105, 1'b1, 1'b1, 32'd5, 32'd5, 1'b1, 1'b1, "R10 bad xo");
        issue(1'b1, 6'd30, 5'd3, 1'b1, 9'd104, 1'b1, 32'd5, 32'd0, 1'b1, 1'b1, "R10 bad prim");
        // R11: idle after activity
        idle("R11 idle");
        op(9'd104, 1'b0, 1'b0, 32'd1, 32'h0, 1'b0, 1'b0, "R11 back to back a");
        op(9'd104, 1'b0, 1'b0, 32'd2, 32'h0, 1'b0, 1'b0, "R11 back to back b");
        idle("R11 idle 2");

        for (int i = 0; i < 600; i++) begin
            logic [8:0] xo;
            logic [5:0] p;
            string      tag;
            case ($urandom_range(0, 9))
                0, 1:    xo = 9'd104;
                2, 3:    xo = 9'd136;
                4, 5:    xo = 9'd200;
                6, 7:    xo = 9'd232;
                default: xo = 9'($urandom());
            endcase
            p = ($urandom_range(0, 15) == 0) ? 6'($urandom()) : 6'd31;
            case (xo)
                9'd104:  tag = "R5 random neg";
                9'd136:  tag = "R2 random subfe";
                9'd200:  tag = "R3 random subfze";
                9'd232:  tag = "R4 random subfme";
                default: tag = "R10 random other";
            endcase
            if ($urandom_range(0, 7) == 0) begin
                idle("R11 random idle");
            end else begin
                issue(1'b1, p, 5'($urandom()), 1'($urandom()), xo, 1'($urandom()),
                      pick_val(), pick_val(), 1'($urandom()), 1'($urandom()), tag);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule